// File: doc/BRIEF.md
# Output Buffer with Zero Backfill

This block is a single-clock word buffer between a producing engine and a host reader. The producer offers words with a valid/ready pair and the host drains them with a second valid/ready pair. While there is room, every producer word is stored. When the buffer is full, the producer is held until the host makes room. The result is that the whole system runs at the pace of the slower side, and no data are lost.

A host write strobe seen while the producer is held on a full buffer releases it. From then on the block is in skip mode. Producer words that cannot be stored are accepted, thrown away and tallied in a saturating counter. As room opens up, one zero word enters the buffer for each tallied word, ahead of any later real data. The output stream therefore keeps its length and its order. Skip mode ends once the tally is back to zero and the buffer has room. A clear input empties the buffer and forgets the tally.

Top module: `obuf_zfill`

## Requirements
- R1: After reset, `level` is 0, `empty` is 1, `full` is 0 and `out_valid` is 0.
- R2: Words leave on `out_data` in the order they were stored. `out_valid` is high exactly when the buffer holds at least one word. A word leaves when `out_valid` and `out_ready` are both high at a rising edge.
- R3: `level` counts the stored words. `full` is high exactly when `level` equals DEPTH, and a full buffer stays full until a pop or a clear.
- R4: Outside skip mode, a producer word offered to a full buffer sees `prod_ready` low and is not stored until a pop makes room.
- R5: A `host_wr` pulse while the producer is held on a full buffer enters skip mode from the next cycle. In skip mode `prod_ready` is always high, and each word that cannot be stored is dropped and tallied. The word that was held is the first one dropped.
- R6: A `host_wr` pulse while the producer is not held has no effect: a later full buffer still holds the producer.
- R7: Once room exists, one all-zero word is stored for each tallied drop. All these zeros are stored before any later producer word.
- R8: Skip mode ends when the tally is zero and the buffer is not full. After that, a full buffer holds the producer again, and the held word is stored once room appears.
- R9: The drop tally is CW bits wide and saturates at 2^CW-1. Any further drops are lost without adding zeros.
- R10: `clr` empties the buffer, clears the tally and leaves skip mode. After a clear no backfill zeros appear, and the next producer word is the first word out.
- R11: A store (real or zero) and a pop in the same cycle leave `level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of buffer, tally and skip mode |
| prod_valid | input | 1 | Producer offers a word |
| prod_data | input | DW | Producer word |
| prod_ready | output | 1 | Producer word taken this cycle (stored or dropped) |
| host_wr | input | 1 | Host write-cycle strobe |
| out_valid | output | 1 | A word is available to the host |
| out_data | output | DW | Oldest stored word |
| out_ready | input | 1 | Host takes the word |
| level | output | $clog2(DEPTH+1) | Number of stored words |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no words |

## Verification
The hardest state to reach is skip mode with a saturated tally. It needs a full buffer, a held producer, a host write that lands during the hold, and more drops than the counter can count. The bench builds the block with a small depth and a 3-bit tally. It fills the buffer with the host idle, holds the producer, pulses `host_wr`, and then offers more words than the tally can hold. Only after that does it let the host drain, so the scoreboard can count the zeros that appear and where they fall in the stream.

// File: rtl/obuf_zfill.sv
module obuf_zfill #(
  parameter int DW = 16,
  parameter int DEPTH = 4096,
  parameter int CW = 24,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          prod_valid,
  input  logic [DW-1:0] prod_data,
  output logic          prod_ready,
  input  logic          host_wr,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam logic [CW-1:0] MISS_MAX = '1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] occ;
  logic [CW-1:0] miss;
  logic          skip;

  logic owed, pop, zfill, take, drop, stalled, wr;
  logic [DW-1:0] wdata;

  assign owed    = miss != '0;
  assign full    = occ == LW'(DEPTH);
  assign empty   = occ == '0;
  assign level   = occ;
  assign out_valid = !empty;
  assign out_data  = mem[rp];

  assign pop     = out_valid & out_ready & ~clr;
  assign zfill   = owed & ~full & ~clr;
  assign take    = prod_valid & ~owed & ~full & ~clr;
  assign drop    = prod_valid & skip & (full | owed) & ~clr;
  assign stalled = prod_valid & ~skip & full;
  assign prod_ready = take | drop;
  assign wr      = take | zfill;
  assign wdata   = zfill ? '0 : prod_data;

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      occ  <= '0;
      miss <= '0;
      skip <= 1'b0;
    end else if (clr) begin
      wp   <= '0;
      rp   <= '0;
      occ  <= '0;
      miss <= '0;
      skip <= 1'b0;
    end else begin
      if (wr)  wp <= wp + AW'(1);
      if (pop) rp <= rp + AW'(1);
      case ({wr, pop})
        2'b10:   occ <= occ + LW'(1);
        2'b01:   occ <= occ - LW'(1);
        default: occ <= occ;
      endcase
      if (drop && !zfill && miss != MISS_MAX) miss <= miss + CW'(1);
      else if (zfill && !drop)                miss <= miss - CW'(1);
      if (stalled && host_wr)          skip <= 1'b1;
      else if (skip && !owed && !full) skip <= 1'b0;
    end
  end
endmodule

module obuf_zfill_chk #(
  parameter int DEPTH = 4096,
  parameter int LW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          prod_valid,
  input logic          prod_ready,
  input logic          out_valid,
  input logic [LW-1:0] level,
  input logic          full,
  input logic          empty,
  input logic          wr,
  input logic          pop,
  input logic          skip
);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prod_valid && !prod_ready && !clr |=> level <= $past(level));

  // R5
  skip_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip && prod_valid && !clr |-> prod_ready);

  // R10
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty && !out_valid && level == '0);

  // R11
  pushpop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && pop |=> level == $past(level));

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop && !clr |=> full);
endmodule

bind obuf_zfill obuf_zfill_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .prod_valid(prod_valid),
  .prod_ready(prod_ready), .out_valid(out_valid), .level(level),
  .full(full), .empty(empty), .wr(wr), .pop(pop), .skip(skip)
);

// File: tb/test_obuf_zfill.sv
module test_obuf_zfill;
  localparam int CLK_P = 10;
  localparam int T_DW = 8;
  localparam int T_DEPTH = 8;
  localparam int T_CW = 3;
  localparam int T_LW = $clog2(T_DEPTH + 1);

  logic clk = 0, rst_n = 0, clr = 0, prod_valid = 0, host_wr = 0, out_ready = 0;
  logic [T_DW-1:0] prod_data = '0;
  logic prod_ready, out_valid, full, empty;
  logic [T_DW-1:0] out_data;
  logic [T_LW-1:0] level;

  int total = 0, bad = 0;
  string cur_req = "R2";
  logic [T_DW-1:0] exp_q[$];

  obuf_zfill #(.DW(T_DW), .DEPTH(T_DEPTH), .CW(T_CW)) i_obuf_zfill (
    .clk(clk), .rst_n(rst_n), .clr(clr), .prod_valid(prod_valid),
    .prod_data(prod_data), .prod_ready(prod_ready), .host_wr(host_wr),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .level(level), .full(full), .empty(empty)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL %s actual=%0h expected=none", cur_req, out_data);
      end else begin
        logic [T_DW-1:0] e;
        e = exp_q.pop_front();
        chk(cur_req, 32'(out_data), 32'(e));
      end
    end
  end

  task automatic push(input logic [T_DW-1:0] d);
    @(posedge clk); #1;
    prod_valid = 1; prod_data = d;
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      if (prod_ready) break;
    end
    @(posedge clk); #1;
    prod_valid = 0;
  endtask

  task automatic fill(input int n, input logic [T_DW-1:0] base);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(base + T_DW'(i));
      push(base + T_DW'(i));
    end
  endtask

  task automatic hold_check(input string req, input logic [T_DW-1:0] d, input int n);
    @(posedge clk); #1;
    prod_valid = 1; prod_data = d;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, 32'(prod_ready), 0);
      chk(req, 32'(level), T_DEPTH);
    end
  endtask

  task automatic abort_hold;
    @(posedge clk); #1; host_wr = 1;
    @(negedge clk); chk("R5", 32'(prod_ready), 0);
    @(posedge clk); #1; host_wr = 0;
    @(negedge clk); chk("R5", 32'(prod_ready), 1);
    @(posedge clk); #1; prod_valid = 0;
    @(negedge clk); chk("R5", 32'(level), T_DEPTH);
  endtask

  task automatic drain;
    @(posedge clk); #1; out_ready = 1;
    for (int g = 0; g < 300; g++) begin
      @(negedge clk); #1;
      if (exp_q.size() == 0 && empty) break;
    end
    chk(cur_req, 32'(exp_q.size()), 0);
    @(posedge clk); #1; out_ready = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", 32'(level), 0);
    chk("R1", 32'(empty), 1);
    chk("R1", 32'(full), 0);
    chk("R1", 32'(out_valid), 0);

    // R2 / R3: ordering and occupancy
    cur_req = "R2";
    fill(5, 8'h11);
    @(negedge clk);
    chk("R3", 32'(level), 5);
    chk("R2", 32'(out_valid), 1);
    drain();

    // R11: simultaneous store and pop
    cur_req = "R11";
    fill(3, 8'h21);
    @(posedge clk); #1;
    exp_q.push_back(8'h77);
    prod_valid = 1; prod_data = 8'h77; out_ready = 1;
    @(negedge clk); chk("R11", 32'(prod_ready), 1);
    @(posedge clk); #1; prod_valid = 0; out_ready = 0;
    @(negedge clk); chk("R11", 32'(level), 3);
    drain();

    // R6: host write while not held is ignored; then R3 / R4 hold
    @(posedge clk); #1; host_wr = 1;
    @(posedge clk); #1; host_wr = 0;
    cur_req = "R7";
    fill(8, 8'h31);
    @(negedge clk);
    chk("R3", 32'(full), 1);
    hold_check("R6", 8'h99, 1);
    hold_check("R4", 8'h99, 4);
    abort_hold();
    push(8'h9A);
    push(8'h9B);
    @(negedge clk); chk("R5", 32'(level), T_DEPTH);
    repeat (3) exp_q.push_back('0);
    drain();
    exp_q.push_back(8'hA5);
    push(8'hA5);
    drain();

    // R8: skip mode has ended, full holds again
    cur_req = "R8";
    fill(8, 8'h41);
    hold_check("R8", 8'hB6, 4);
    exp_q.push_back(8'hB6);
    @(posedge clk); #1; out_ready = 1;
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      if (prod_ready) break;
    end
    @(posedge clk); #1; prod_valid = 0;
    drain();

    // R9: tally saturates at 7
    cur_req = "R9";
    fill(8, 8'h51);
    hold_check("R4", 8'hC0, 1);
    abort_hold();
    for (int i = 0; i < 10; i++) push(8'hC1 + T_DW'(i));
    repeat (7) exp_q.push_back('0);
    drain();
    @(negedge clk); chk("R9", 32'(level), 0);

    // R10: clear cancels buffer and backfill
    cur_req = "R10";
    fill(8, 8'h61);
    hold_check("R4", 8'hD0, 1);
    abort_hold();
    push(8'hD1);
    push(8'hD2);
    @(posedge clk); #1; clr = 1;
    @(posedge clk); #1; clr = 0;
    @(negedge clk);
    chk("R10", 32'(empty), 1);
    chk("R10", 32'(level), 0);
    chk("R10", 32'(out_valid), 0);
    exp_q.delete();
    @(posedge clk); #1; out_ready = 1;
    repeat (20) @(negedge clk);
    chk("R10", 32'(level), 0);
    @(posedge clk); #1; out_ready = 0;
    exp_q.push_back(8'h3C);
    push(8'h3C);
    @(negedge clk); chk("R10", 32'(level), 1);
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule